// File: doc/BRIEF.md
# Interrupt Cause Aggregation Controller

This block collects raw event pulses from three 32-bit interrupt groups (receive, transmit and miscellaneous) into sticky cause registers and drives a single level interrupt line. Every group has its own mask, changed through separate set and clear write strobes. Each cause bit has its own clearing style: software either writes ones to clear it, or the bit clears when software reads it. A read-only view returns each group's unmasked pending bits.

A three-bit summary register holds one bit per group. A bit is set while that group has an unmasked pending cause, and the whole register clears when it is read. A software summary mask then decides which groups may raise the interrupt output.

Software reaches all of this through a word-addressed read/write port. Read data comes back one cycle after the read strobe. The address map is as follows. Group g (0 receive, 1 transmit, 2 miscellaneous) occupies words 8g to 8g+4:
- +0 is the cause register.
- +1 is mask-set; reading it returns the mask.
- +2 is mask-clear; reading it returns zero.
- +3 is the clear-mode register.
- +4 is the masked view.

Word 24 is the summary register and word 25 is the summary mask. Unmapped words read as zero.

Top module: `irq_cause_agg`

## Requirements
- R1: After reset every cause register and every clear-mode register is zero, every group mask and the summary mask are all ones, the summary register is zero and `irq` is low.
- R2: A 1 on bit j of a group's event input sets cause bit j on the next clock edge, whatever the mask, and the bit stays set until it is cleared.
- R3: Writing word 8g+1 sets mask bits where the write data is 1. Writing word 8g+2 clears mask bits where the data is 1. Data bits of 0 leave the mask unchanged. The mask reads back at word 8g+1.
- R4: Word 8g+4 reads as the group's cause AND NOT mask.
- R5: Summary bit g (bit 0 receive, bit 1 transmit, bit 2 miscellaneous) is set one edge after group g has any unmasked pending cause. A read of word 24 returns the summary and clears it, and a bit whose group is still pending is set again on the same edge.
- R6: For a bit whose clear-mode bit is 0, writing word 8g with that data bit at 1 clears it. Writing back a value just read clears exactly those bits.
- R7: For a bit whose clear-mode bit is 1, a read of word 8g returns the bit and clears it. Writes to word 8g leave such bits unchanged.
- R8: An event arriving on the same edge as a clear of the same bit, by write or by read, leaves the bit set.
- R9: `irq` is high when any summary bit g is set while bit g of the summary mask is 0. The summary mask reads back at word 25.
- R10: The clear-mode register of each group is written and read at word 8g+3, one bit per cause bit.
- R11: Read data for a read strobe appears on `rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| rx_evt | input | 32 | Receive group raw events |
| tx_evt | input | 32 | Transmit group raw events |
| misc_evt | input | 32 | Miscellaneous group raw events |
| irq | output | 1 | Level interrupt output |

## Verification
The gating path is tried with event patterns that fall entirely inside the unmasked bits, partly inside, and entirely under the mask. These cases separate the raw cause, the masked view and the summary bit. The patterns cover single low bits, the top bit, alternating bits and full words in each of the three groups, which exposes swapped groups or bit positions.

Clear-style patterns mix the two modes inside one group, so a read that clears write-to-clear bits, or a write that clears read-to-clear bits, shows up at once. Event-plus-clear collisions are driven in both modes. The summary mask is swept over values that enable all groups, one group, and none.

// File: rtl/irq_cause_agg_pkg.sv
package irq_cause_agg_pkg;
    localparam logic [2:0] OFF_CAUSE = 3'd0;
    localparam logic [2:0] OFF_MSET  = 3'd1;
    localparam logic [2:0] OFF_MCLR  = 3'd2;
    localparam logic [2:0] OFF_MODE  = 3'd3;
    localparam logic [2:0] OFF_VIEW  = 3'd4;
    localparam int unsigned GRP_STRIDE  = 8;
    localparam int unsigned SUMMARY_WORD = 24;
    localparam int unsigned SMASK_WORD   = 25;
endpackage

// File: rtl/irq_cause_group.sv
module irq_cause_group #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cause,
    input  logic          wr_mset,
    input  logic          wr_mclr,
    input  logic          wr_mode,
    input  logic          rd_cause,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] evt,
    output logic [DW-1:0] cause_o,
    output logic [DW-1:0] mask_o,
    output logic [DW-1:0] mode_o,
    output logic [DW-1:0] view_o
);
    typedef struct packed {
        logic [DW-1:0] cause;
        logic [DW-1:0] mask;
        logic [DW-1:0] mode;
    } grp_st_t;

    grp_st_t st_d, st_q;
    logic [DW-1:0] clr_d;

    always_comb begin
        st_d  = st_q;
        clr_d = '0;
        // write-to-clear only touches bits in mode 0
        if (wr_cause) clr_d = clr_d | (wdata & ~st_q.mode);
        // read-to-clear only touches bits in mode 1
        if (rd_cause) clr_d = clr_d | st_q.mode;
        // a fresh event overrides any clear (R8)
        st_d.cause = (st_q.cause & ~clr_d) | evt;
        if (wr_mset) st_d.mask = st_q.mask | wdata;
        if (wr_mclr) st_d.mask = st_q.mask & ~wdata;
        if (wr_mode) st_d.mode = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cause <= '0;
            st_q.mask  <= '1;
            st_q.mode  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cause_o = st_q.cause;
    assign mask_o  = st_q.mask;
    assign mode_o  = st_q.mode;
    assign view_o  = st_q.cause & ~st_q.mask;
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
    parameter int NG = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NG-1:0] pend,
    input  logic          rd_summary,
    input  logic          wr_smask,
    input  logic [DW-1:0] wdata,
    output logic [NG-1:0] summary_o,
    output logic [DW-1:0] smask_o,
    output logic          irq
);
    typedef struct packed {
        logic [NG-1:0] summary;
        logic [DW-1:0] smask;
    } sum_st_t;

    sum_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear on read, but a still-pending group sets its bit again
        st_d.summary = (rd_summary ? '0 : st_q.summary) | pend;
        if (wr_smask) st_d.smask = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.summary <= '0;
            st_q.smask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign summary_o = st_q.summary;
    assign smask_o   = st_q.smask;
    assign irq       = |(st_q.summary & ~st_q.smask[NG-1:0]);
endmodule

// File: rtl/irq_cause_agg.sv
module irq_cause_agg
    import irq_cause_agg_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] rx_evt,
    input  logic [DW-1:0] tx_evt,
    input  logic [DW-1:0] misc_evt,
    output logic          irq
);
    localparam int NG = 3;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [NG-1:0][DW-1:0] evt_w;
    logic [NG-1:0][DW-1:0] cause_w;
    logic [NG-1:0][DW-1:0] mask_w;
    logic [NG-1:0][DW-1:0] mode_w;
    logic [NG-1:0][DW-1:0] view_w;
    logic [NG-1:0]         hit_w;
    logic [NG-1:0]         pend_w;
    logic [NG-1:0]         summary_w;
    logic [DW-1:0]         smask_w;
    logic [2:0]            off_w;
    logic                  sum_hit_w;
    logic                  smask_hit_w;

    assign evt_w[0]    = rx_evt;
    assign evt_w[1]    = tx_evt;
    assign evt_w[2]    = misc_evt;
    assign off_w       = addr[2:0];
    assign sum_hit_w   = (addr == AW'(SUMMARY_WORD));
    assign smask_hit_w = (addr == AW'(SMASK_WORD));

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign hit_w[g]  = (addr[AW-1:3] == (AW-3)'(g));
        assign pend_w[g] = |view_w[g];

        irq_cause_group #(.DW(DW)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_cause (wr_en && hit_w[g] && off_w == OFF_CAUSE),
            .wr_mset  (wr_en && hit_w[g] && off_w == OFF_MSET),
            .wr_mclr  (wr_en && hit_w[g] && off_w == OFF_MCLR),
            .wr_mode  (wr_en && hit_w[g] && off_w == OFF_MODE),
            .rd_cause (rd_en && hit_w[g] && off_w == OFF_CAUSE),
            .wdata    (wdata),
            .evt      (evt_w[g]),
            .cause_o  (cause_w[g]),
            .mask_o   (mask_w[g]),
            .mode_o   (mode_w[g]),
            .view_o   (view_w[g])
        );
    end

    irq_summary #(.NG(NG), .DW(DW)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend_w),
        .rd_summary (rd_en && sum_hit_w),
        .wr_smask   (wr_en && smask_hit_w),
        .wdata      (wdata),
        .summary_o  (summary_w),
        .smask_o    (smask_w),
        .irq        (irq)
    );

    always_comb begin
        st_d.rdata = '0;
        if (rd_en) begin
            for (int g = 0; g < NG; g++) begin
                if (hit_w[g]) begin
                    case (off_w)
                        OFF_CAUSE: st_d.rdata = cause_w[g];
                        OFF_MSET:  st_d.rdata = mask_w[g];
                        OFF_MODE:  st_d.rdata = mode_w[g];
                        OFF_VIEW:  st_d.rdata = view_w[g];
                        default:   st_d.rdata = '0;
                    endcase
                end
            end
            if (sum_hit_w)   st_d.rdata = {{(DW-NG){1'b0}}, summary_w};
            if (smask_hit_w) st_d.rdata = smask_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.rdata <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/irq_cause_agg_chk.sv
module irq_cause_agg_chk #(
    parameter int DW = 32,
    parameter int AW = 5,
    parameter int NG = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [AW-1:0]         addr,
    input logic [DW-1:0]         wdata,
    input logic [NG-1:0][DW-1:0] evt,
    input logic [NG-1:0][DW-1:0] cause,
    input logic [NG-1:0][DW-1:0] mask,
    input logic [NG-1:0][DW-1:0] mode,
    input logic [NG-1:0]         summary,
    input logic [DW-1:0]         smask,
    input logic                  irq
);
    logic [NG-1:0] pend_c;

    for (genvar g = 0; g < NG; g++) begin : g_chk
        assign pend_c[g] = |(cause[g] & ~mask[g]);

        assert_evt_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[g] != '0) |=> ((cause[g] & $past(evt[g])) == $past(evt[g])));

        assert_mask_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == AW'(g*8+1)) |=> ((mask[g] & $past(wdata)) == $past(wdata)));

        assert_mask_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == AW'(g*8+2)) |=> ((mask[g] & $past(wdata)) == '0));

        assert_pend_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pend_c[g] |=> summary[g]);

        assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !rd_en && addr == AW'(g*8)) |=>
            ((cause[g] & $past(wdata & ~mode[g] & ~evt[g])) == '0));

        assert_cor_ignores_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !rd_en && addr == AW'(g*8)) |=>
            ((cause[g] & $past(cause[g] & mode[g])) == $past(cause[g] & mode[g])));
    end

    assert_summary_rd_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(24) && pend_c == '0) |=> (summary == '0));

    assert_irq_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&smask[NG-1:0]) |-> !irq);

    assert_irq_needs_summary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (summary == '0) |-> !irq);
endmodule

bind irq_cause_agg irq_cause_agg_chk #(.DW(DW), .AW(AW), .NG(NG)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .evt     (evt_w),
    .cause   (cause_w),
    .mask    (mask_w),
    .mode    (mode_w),
    .summary (summary_w),
    .smask   (smask_w),
    .irq     (irq)
);

// File: tb/irq_cause_agg_tb.sv
`timescale 1ns/1ps
module irq_cause_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] evt [3];
    logic        irq;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    initial begin
        evt[0] = '0; evt[1] = '0; evt[2] = '0;
    end

    irq_cause_agg u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_evt(evt[0]), .tx_evt(evt[1]),
        .misc_evt(evt[2]), .irq(irq)
    );

    localparam int NV = 6;
    localparam int          V_GRP [NV] = '{0, 0, 1, 1, 2, 2};
    localparam logic [31:0] V_UNM [NV] = '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_0000,
                                           32'h8000_0000, 32'hAAAA_AAAA, 32'h00FF_00FF};
    localparam logic [31:0] V_EVT [NV] = '{32'h0000_0001, 32'hF0F0_0F0F, 32'h1234_5678,
                                           32'h8000_0001, 32'h5555_5555, 32'hFFFF_FFFF};
    localparam logic [31:0] V_VIEW[NV] = '{32'h0000_0001, 32'h0000_0F0F, 32'h0000_0000,
                                           32'h8000_0000, 32'h0000_0000, 32'h00FF_00FF};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; d = rdata;
    endtask

    task automatic pulse(input int g, input logic [31:0] v);
        @(negedge clk); evt[g] = v;
        @(negedge clk); evt[g] = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [4:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'd0, irq}, 32'd0);
        for (int g = 0; g < 3; g++) begin
            b = 5'(g * 8);
            rd(b, v);      check("R1 cause", v, 32'h0);
            rd(b + 1, v);  check("R1 mask", v, 32'hFFFF_FFFF);
            rd(b + 3, v);  check("R1 mode", v, 32'h0);
        end
        rd(5'd24, v); check("R1 summary", v, 32'h0);
        rd(5'd25, v); check("R1 smask", v, 32'hFFFF_FFFF);

        // vector table: main gating path
        for (int i = 0; i < NV; i++) begin
            b = 5'(V_GRP[i] * 8);
            wr(b + 2, V_UNM[i]);
            pulse(V_GRP[i], V_EVT[i]);
            rd(b + 4, v); check("R4 view", v, V_VIEW[i]);
            rd(b, v);     check("R2 cause", v, V_EVT[i]);
            rd(5'd24, v); check("R5 summary", v, (V_VIEW[i] != 0) ? (32'd1 << V_GRP[i]) : 32'd0);
            wr(b, V_EVT[i]);
            rd(b, v);     check("R6 cleared", v, 32'h0);
            wr(b + 1, 32'hFFFF_FFFF);
            rd(b + 1, v); check("R3 remask", v, 32'hFFFF_FFFF);
            rd(5'd24, v);
            rd(5'd24, v); check("R5 read clears", v, 32'h0);
        end

        // R3 partial set/clear
        wr(5'd10, 32'h0000_000F);
        rd(5'd9, v);  check("R3 partial clr", v, 32'hFFFF_FFF0);
        wr(5'd9, 32'h0000_0003);
        rd(5'd9, v);  check("R3 partial set", v, 32'hFFFF_FFF3);
        rd(5'd10, v); check("R3 clr word reads zero", v, 32'h0);
        wr(5'd9, 32'hFFFF_FFFF);

        // R6 write back a read value, new event survives
        pulse(1, 32'h0000_00FF);
        rd(5'd8, v);
        pulse(1, 32'h0000_0100);
        wr(5'd8, v);
        rd(5'd8, v);  check("R6 write-back exact", v, 32'h0000_0100);
        wr(5'd8, 32'h0000_0100);

        // R9 summary mask gating
        wr(5'd2, 32'h0000_0008);
        pulse(0, 32'h0000_0008);
        @(negedge clk);
        check("R9 blocked at reset", {31'd0, irq}, 32'd0);
        wr(5'd25, 32'hFFFF_FFF8); check("R9 all enabled", {31'd0, irq}, 32'd1);
        wr(5'd25, 32'hFFFF_FFFD); check("R9 only tx", {31'd0, irq}, 32'd0);
        wr(5'd25, 32'hFFFF_FFFE); check("R9 only rx", {31'd0, irq}, 32'd1);
        rd(5'd25, v); check("R9 smask readback", v, 32'hFFFF_FFFE);
        wr(5'd25, 32'hFFFF_FFFF); check("R9 all blocked", {31'd0, irq}, 32'd0);
        wr(5'd0, 32'h0000_0008);
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd24, v);
        rd(5'd24, v); check("R5 idle", v, 32'h0);

        // R8 event against write-clear
        pulse(0, 32'h0000_0020);
        @(negedge clk); wr_en = 1'b1; addr = 5'd0; wdata = 32'h0000_0020; evt[0] = 32'h0000_0020;
        @(negedge clk); wr_en = 1'b0; evt[0] = '0;
        rd(5'd0, v);  check("R8 event beats write", v, 32'h0000_0020);
        wr(5'd0, 32'h0000_0020);

        // R10 / R7 mixed modes in the misc group
        wr(5'd19, 32'hFFFF_0000);
        rd(5'd19, v); check("R10 mode readback", v, 32'hFFFF_0000);
        pulse(2, 32'hFFFF_FFFF);
        rd(5'd16, v); check("R7 read returns", v, 32'hFFFF_FFFF);
        rd(5'd16, v); check("R7 read cleared upper only", v, 32'h0000_FFFF);
        pulse(2, 32'h0001_0000);
        wr(5'd16, 32'h0001_0000);
        rd(5'd16, v); check("R7 write ignored", v, 32'h0001_FFFF);
        rd(5'd16, v); check("R7 second read", v, 32'h0000_FFFF);

        // R8 event against read-clear
        @(negedge clk); rd_en = 1'b1; addr = 5'd16; evt[2] = 32'h0010_0000;
        @(negedge clk); rd_en = 1'b0; evt[2] = '0; v = rdata;
        check("R11 read data old value", v, 32'h0000_FFFF);
        rd(5'd16, v); check("R8 event beats read", v, 32'h0010_FFFF);
        rd(5'd16, v); check("R7 cleared again", v, 32'h0000_FFFF);
        wr(5'd16, 32'h0000_FFFF);
        rd(5'd16, v); check("R6 lower cleared", v, 32'h0);

        done = 1;
        summary();
        $finish;
    end
endmodule